// File: doc/BRIEF.md
# Rail Power-Good Supervisor

This block watches three regulated supply rails through two comparator flags per rail: one that reports the rail has sagged below its low threshold (85 % of nominal) and one that reports it has climbed above its high threshold (90 % of nominal). Each flag is filtered over a run of millisecond ticks. The filtered flags set or clear a per-rail "qualified" state. Between the two thresholds that state holds its last value, which gives hysteresis.

When every rail is qualified and the sequencer reports that start-up is finished, a hold timer counts a full reset period. Only after that period does the power-good output assert. The output signal drives the enable of an open-drain pull-down. A static strap selects whether power-good is active-high (the pull-down is released when good) or active-low.

A separate start-up watchdog is armed when soft-start begins. If the raw high-threshold flags of all rails are not seen together within the watchdog window, a sticky fault flag is raised.

Top module: `pg_supervisor`

## Requirements
- R1: While `rst` is high and in the first cycles after it, `pg_pd_en` shows the deasserted level (1 when `pol_low`=0, 0 when `pol_low`=1) and `wdog_fault` is 0. After reset every rail counts as not qualified.
- R2: A change on a `lo_flag` or `hi_flag` bit takes effect only when the new value has been present at DG_TICKS consecutive `tick_ms` pulses. A change that lasts fewer ticks has no effect.
- R3: A rail becomes qualified when its filtered high flag is 1 and its filtered low flag is 0. It becomes unqualified when its filtered low flag is 1, and this holds even when the high flag is also 1. With both filtered flags at 0, the rail keeps its previous state.
- R4: Power-good asserts only when all rails are qualified, `seq_done` is 1, and RESET_TICKS ticks have been counted after the last of these conditions became true.
- R5: Power-good deasserts within three clock cycles after any rail loses qualification or `seq_done` falls. The hold count then restarts from zero.
- R6: When `pol_low`=0, asserted power-good gives `pg_pd_en`=0 and deasserted gives 1. When `pol_low`=1, asserted gives 1 and deasserted gives 0. `pg_pd_en` is registered one cycle after the internal power-good state.
- R7: A pulse on `ss_start` arms the watchdog. If no tick among the next WDOG_TICKS ticks sees every `hi_flag` bit at 1, `wdog_fault` rises on the WDOG_TICKS-th tick. If one tick does see them all, the watchdog disarms without a fault.
- R8: `wdog_fault` stays 1 until `rst` or a new `ss_start` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| lo_flag | input | NCH | Per-rail flag: rail below low threshold |
| hi_flag | input | NCH | Per-rail flag: rail above high threshold |
| seq_done | input | 1 | Start-up sequencing finished |
| ss_start | input | 1 | Pulse at soft-start begin; arms watchdog, clears fault |
| pol_low | input | 1 | Strap: 0 selects active-high power-good, 1 selects active-low |
| pg_pd_en | output | 1 | Enable for the open-drain pull-down of the power-good pin |
| wdog_fault | output | 1 | Sticky start-up watchdog fault |

## Verification
The bench uses a small configuration (3-tick filter, 6-tick hold, 4-tick watchdog). It steps through every tick count around each threshold, so that the output is checked at each tick of a rise and of a fall. The patterns are the following: all rails rising together, one rail sagging, flag glitches one tick shorter than the filter, a rail parked between the thresholds, both flags set at once, and `seq_done` dropping midway through the hold count. Together these separate an off-by-one filter or hold count, a missing hysteresis hold, the wrong flag priority and a hold count that does not restart. Both strap settings are run, and so are watchdog runs that time out and that are satisfied in time.

// File: rtl/pg_sup_pkg.sv
package pg_sup_pkg;
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef enum logic [0:0] {WD_IDLE = 1'b0, WD_ARMED = 1'b1} wd_state_t;
endpackage

// File: rtl/pg_tick_filter.sv
module pg_tick_filter
  import pg_sup_pkg::*;
#(
  parameter int TICKS = 11,
  parameter bit INIT  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int CW = cnt_w(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt    <= INIT;
      run_cnt <= '0;
    end else if (raw == filt) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (run_cnt == LAST) begin
        filt    <= raw;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_rail_qual.sv
module pg_rail_qual #(
  parameter int DG_TICKS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lo_raw,
  input  logic hi_raw,
  output logic hi_filt,
  output logic ok
);
  logic lo_filt;

  pg_tick_filter #(.TICKS(DG_TICKS), .INIT(1'b1)) i_lo (
    .clk(clk), .rst(rst), .tick(tick), .raw(lo_raw), .filt(lo_filt)
  );

  pg_tick_filter #(.TICKS(DG_TICKS), .INIT(1'b0)) i_hi (
    .clk(clk), .rst(rst), .tick(tick), .raw(hi_raw), .filt(hi_filt)
  );

  // low flag has priority: fail-safe when the pair disagrees
  always_ff @(posedge clk) begin
    if (rst)          ok <= 1'b0;
    else if (lo_filt) ok <= 1'b0;
    else if (hi_filt) ok <= 1'b1;
  end
endmodule

// File: rtl/pg_hold_timer.sv
module pg_hold_timer
  import pg_sup_pkg::*;
#(
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic pg_q
);
  localparam int CW = cnt_w(TICKS);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pg_q <= 1'b0;
    end else begin
      if (!run)                   cnt <= '0;
      else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
      pg_q <= run && (cnt == LIM);
    end
  end
endmodule

// File: rtl/pg_start_wdog.sv
module pg_start_wdog
  import pg_sup_pkg::*;
#(
  parameter int TICKS = 11,
  parameter int NCH   = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           start,
  input  logic [NCH-1:0] hi_raw,
  output logic           fault
);
  localparam int CW = cnt_w(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  wd_state_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= WD_IDLE;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (start) begin
      st    <= WD_ARMED;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (st == WD_ARMED && tick) begin
      if (&hi_raw) begin
        st <= WD_IDLE;
      end else if (cnt == LAST) begin
        st    <= WD_IDLE;
        fault <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor #(
  parameter int NCH         = 3,
  parameter int DG_TICKS    = 11,
  parameter int RESET_TICKS = 100,
  parameter int WDOG_TICKS  = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_ms,
  input  logic [NCH-1:0] lo_flag,
  input  logic [NCH-1:0] hi_flag,
  input  logic           seq_done,
  input  logic           ss_start,
  input  logic           pol_low,
  output logic           pg_pd_en,
  output logic           wdog_fault
);
  logic [NCH-1:0] rail_ok;
  logic [NCH-1:0] f_hi_vec;
  logic           all_run;
  logic           pg_q;

  for (genvar g = 0; g < NCH; g++) begin : g_rail
    pg_rail_qual #(.DG_TICKS(DG_TICKS)) i_qual (
      .clk(clk), .rst(rst), .tick(tick_ms),
      .lo_raw(lo_flag[g]), .hi_raw(hi_flag[g]),
      .hi_filt(f_hi_vec[g]), .ok(rail_ok[g])
    );
  end

  assign all_run = (&rail_ok) && seq_done;

  pg_hold_timer #(.TICKS(RESET_TICKS)) i_hold (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(all_run), .pg_q(pg_q)
  );

  pg_start_wdog #(.TICKS(WDOG_TICKS), .NCH(NCH)) i_wdog (
    .clk(clk), .rst(rst), .tick(tick_ms), .start(ss_start),
    .hi_raw(hi_flag), .fault(wdog_fault)
  );

  // pull-down enable: active-high mode releases the pin when good
  always_ff @(posedge clk) begin
    if (rst) pg_pd_en <= !pol_low;
    else     pg_pd_en <= pol_low ? pg_q : !pg_q;
  end
endmodule

// File: rtl/pg_supervisor_chk.sv
module pg_supervisor_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           tick_ms,
  input logic           ss_start,
  input logic           pol_low,
  input logic           pg_pd_en,
  input logic           wdog_fault,
  input logic           pg_q,
  input logic           all_run,
  input logic [NCH-1:0] f_hi_vec
);
  assert_filter_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_ms |=> $stable(f_hi_vec));

  assert_pg_needs_rails_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_q) |-> $past(all_run));

  assert_pg_drops_R5: assert property (@(posedge clk) disable iff (rst)
    !all_run |=> !pg_q);

  assert_polarity_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pg_pd_en == ($past(pol_low) ~^ $past(pg_q))));

  assert_fault_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_fault) |-> $past(tick_ms));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (wdog_fault && !ss_start) |=> wdog_fault);
endmodule

bind pg_supervisor pg_supervisor_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .ss_start(ss_start),
  .pol_low(pol_low), .pg_pd_en(pg_pd_en), .wdog_fault(wdog_fault),
  .pg_q(pg_q), .all_run(all_run), .f_hi_vec(f_hi_vec)
);

// File: tb/test_pg_supervisor.sv
module test_pg_supervisor;
  localparam int NCH = 3;
  localparam int DG  = 3;
  localparam int RST = 6;
  localparam int WD  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick_ms = 1'b0;
  logic [NCH-1:0] lo_flag = '1;
  logic [NCH-1:0] hi_flag = '0;
  logic           seq_done = 1'b0;
  logic           ss_start = 1'b0;
  logic           pol_low = 1'b0;
  logic           pg_pd_en;
  logic           wdog_fault;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pg_supervisor #(.NCH(NCH), .DG_TICKS(DG), .RESET_TICKS(RST), .WDOG_TICKS(WD)) i_pg_supervisor (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .lo_flag(lo_flag), .hi_flag(hi_flag),
    .seq_done(seq_done), .ss_start(ss_start), .pol_low(pol_low),
    .pg_pd_en(pg_pd_en), .wdog_fault(wdog_fault)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // expected pin drive from the expected power-good state and the strap
  task automatic chk_pg(input bit good, input string req);
    chk(pg_pd_en, pol_low ? good : !good, req);
  endtask

  task automatic do_tick();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) ss_start = 1'b1;
    @(negedge clk) ss_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state, active-high strap
    repeat (3) @(negedge clk);
    chk_pg(1'b0, "R1 in reset");
    do_reset();
    chk_pg(1'b0, "R1 after reset");
    chk(wdog_fault, 1'b0, "R1 fault after reset");

    // R7 watchdog times out with rails never good
    pulse_start();
    for (int k = 1; k <= WD + 2; k++) begin
      do_tick();
      chk(wdog_fault, (k >= WD), "R7 watchdog expiry tick");
    end
    repeat (3) do_tick();
    chk(wdog_fault, 1'b1, "R8 fault sticky");
    pulse_start();
    @(negedge clk);
    chk(wdog_fault, 1'b0, "R8 fault cleared by start");

    // R2 R4 rails rise together; watchdog satisfied on first tick
    lo_flag = '0; hi_flag = '1; seq_done = 1'b1;
    for (int k = 1; k <= DG + RST + 2; k++) begin
      do_tick();
      chk_pg(k >= DG + RST, "R4 hold count after rise");
    end
    repeat (WD) do_tick();
    chk(wdog_fault, 1'b0, "R7 watchdog satisfied");

    // R3 hysteresis: parked between thresholds
    hi_flag = '0;
    for (int k = 1; k <= DG + 3; k++) begin
      do_tick();
      chk_pg(1'b1, "R3 hold between thresholds");
    end

    // R2 short glitch on low flag of rail 1
    lo_flag[1] = 1'b1;
    repeat (DG - 1) do_tick();
    lo_flag[1] = 1'b0;
    for (int k = 1; k <= DG + 1; k++) begin
      do_tick();
      chk_pg(1'b1, "R2 short glitch ignored");
    end

    // R5 rail 1 sags
    lo_flag[1] = 1'b1;
    for (int k = 1; k <= DG; k++) begin
      do_tick();
      chk_pg(k < DG, "R5 deassert on sag");
    end

    // R5 recovery interrupted by seq_done drop: count restarts
    lo_flag[1] = 1'b0; hi_flag = '1;
    for (int k = 1; k <= DG + RST - 2; k++) begin
      do_tick();
      chk_pg(1'b0, "R4 not yet asserted");
    end
    @(negedge clk) seq_done = 1'b0;
    repeat (2) @(negedge clk);
    seq_done = 1'b1;
    for (int k = 1; k <= RST; k++) begin
      do_tick();
      chk_pg(k >= RST, "R5 count restarted");
    end
    @(negedge clk) seq_done = 1'b0;
    repeat (3) @(negedge clk);
    chk_pg(1'b0, "R5 seq_done low drops output");
    seq_done = 1'b1;
    repeat (RST) do_tick();
    chk_pg(1'b1, "R4 reassert after seq_done");

    // R3 both flags set: low wins
    lo_flag[0] = 1'b1;
    repeat (DG) do_tick();
    chk_pg(1'b0, "R3 low flag priority");
    lo_flag[0] = 1'b0;
    for (int k = 1; k <= DG + RST; k++) begin
      do_tick();
      chk_pg(k >= DG + RST, "R3 requalify after priority");
    end

    // R6 active-low strap
    pol_low = 1'b1;
    do_reset();
    chk_pg(1'b0, "R1 reset active-low");
    chk(pg_pd_en, 1'b0, "R6 active-low deasserted level");
    for (int k = 1; k <= DG + RST; k++) begin
      do_tick();
      chk_pg(k >= DG + RST, "R6 active-low sweep");
    end
    chk(pg_pd_en, 1'b1, "R6 active-low asserted level");

    // R8 reset clears fault
    lo_flag = '1; hi_flag = '0;
    pulse_start();
    repeat (WD) do_tick();
    chk(wdog_fault, 1'b1, "R7 second timeout");
    do_reset();
    chk(wdog_fault, 1'b0, "R8 reset clears fault");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule